// File: doc/BRIEF.md
# Seconds Counter with Match Wrap

This block keeps a running count of seconds for a timer that works in its calendar-style mode. A free-running divider turns the system clock into one tick per second. On each tick the seconds count goes up by one. If the new value is greater than a programmable limit, the count is cleared to zero.

A status flag goes high for one cycle in the cycle where the count reads zero after a tick update. Surrounding logic samples this flag into its own status and interrupt handling.

The 32-bit limit is written as two 16-bit halves through two write strobes that share one data bus. The seconds count is presented on a read port. That port shows the count only while the calendar mode is selected and reads zero otherwise.

Top module: `sec_wrap_counter`

## Requirements
- R1: While counting is active (`en` and `rtc_mode` both high), one tick occurs every `CLK_HZ` clock cycles. The first count change appears `CLK_HZ` rising edges after counting becomes active.
- R2: The limit is `{upper half, lower half}`. A cycle with `lim_lo_wr` high stores `lim_half` into bits 15:0, and a cycle with `lim_hi_wr` high stores it into bits 31:16. Each write takes effect at the next rising edge.
- R3: On a tick the count is first incremented. If the incremented value is strictly greater than the limit, the count becomes 0. Otherwise it takes the incremented value.
- R4: `wrap_flag` is high for exactly the cycle after a tick whose updated count is 0. In that cycle the count reads 0. With a limit of 0, every tick yields count 0 and raises the flag.
- R5: `sec_count` equals the internal count while `rtc_mode` is 1 and reads 0 while `rtc_mode` is 0.
- R6: While counting is inactive, the divider is held at 0, the count keeps its value and no flag is raised. Re-activation restarts a full `CLK_HZ`-cycle period.
- R7: Reset clears the count and the flag and sets the limit to all ones.
- R8: A limit write in the same cycle as a tick does not affect that tick. The compare uses the limit held before the write, and the new limit applies from the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counting enable |
| rtc_mode | input | 1 | Calendar mode select; gates counting and the read port |
| lim_lo_wr | input | 1 | Write strobe for limit bits 15:0 |
| lim_hi_wr | input | 1 | Write strobe for limit bits 31:16 |
| lim_half | input | 16 | Data for either limit half |
| sec_count | output | 32 | Seconds count read port (0 outside calendar mode) |
| wrap_flag | output | 1 | One-cycle pulse when a tick leaves the count at 0 |

## Verification
The two functions that can land in the same cycle are a limit write and the seconds tick. The bench runs the divider up to its last cycle and then presents a lower-half write on the edge that carries the tick. It judges the result by two values: the count after that tick must follow the old limit, and the count after the next tick must follow the new one. Disabling in mid-period is also checked: the bench shows that the next tick still needs a full period.

// File: rtl/sec_ctr_pkg.sv
package sec_ctr_pkg;
    parameter int unsigned SEC_W  = 32;
    parameter int unsigned HALF_W = SEC_W / 2;

    typedef logic [SEC_W-1:0]  sec_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        sec_t count;
        logic flag;
    } core_state_t;
endpackage

// File: rtl/sec_tick_div.sv
module sec_tick_div #(
    parameter int unsigned CLK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    localparam int unsigned DIV_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HZ - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick  = active && (div_q == DIV_LAST);
        div_d = div_q;
        if (!active || tick) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R1: divider never leaves its range
    assert_div_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_LAST);
    // R6: inactive cycle parks the divider at zero
    assert_div_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> div_q == '0);
endmodule

// File: rtl/sec_limit_reg.sv
module sec_limit_reg
    import sec_ctr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lo_wr,
    input  logic  hi_wr,
    input  half_t half,
    output sec_t  limit
);
    sec_t lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (lo_wr) lim_d[HALF_W-1:0]     = half;
        if (hi_wr) lim_d[SEC_W-1:HALF_W] = half;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lim_q <= '1;
        else        lim_q <= lim_d;
    end

    assign limit = lim_q;

    // R2: lower-half write lands in the low bits
    assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> lim_q[HALF_W-1:0] == $past(half));
    // R2: upper-half write lands in the high bits
    assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> lim_q[SEC_W-1:HALF_W] == $past(half));
endmodule

// File: rtl/sec_count_core.sv
module sec_count_core
    import sec_ctr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  sec_t limit,
    output sec_t count,
    output logic flag
);
    core_state_t st_d, st_q;
    logic [SEC_W:0] inc;

    always_comb begin
        inc        = {1'b0, st_q.count} + 1'b1;
        st_d       = st_q;
        st_d.flag  = 1'b0;
        if (tick) begin
            if (inc > {1'b0, limit}) st_d.count = '0;
            else                     st_d.count = inc[SEC_W-1:0];
            st_d.flag = (st_d.count == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign flag  = st_q.flag;

    // R3: a tick either steps the count by one or clears it
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.count == '0) || (st_q.count == $past(st_q.count) + 1'b1));
    // R6: without a tick the count is held
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.count));
    // R4: flag only ever appears with a zero count
    assert_flag_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> st_q.count == '0);
    // R4: flag only follows a tick
    assert_flag_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !st_q.flag);
endmodule

// File: rtl/sec_wrap_counter.sv
module sec_wrap_counter
    import sec_ctr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rtc_mode,
    input  logic              lim_lo_wr,
    input  logic              lim_hi_wr,
    input  logic [HALF_W-1:0] lim_half,
    output logic [SEC_W-1:0]  sec_count,
    output logic              wrap_flag
);
    logic active;
    logic tick;
    sec_t limit;
    sec_t count;

    assign active = en && rtc_mode;

    sec_tick_div #(.CLK_HZ(CLK_HZ)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (tick)
    );

    sec_limit_reg u_lim (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_wr (lim_lo_wr),
        .hi_wr (lim_hi_wr),
        .half  (lim_half),
        .limit (limit)
    );

    sec_count_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .limit (limit),
        .count (count),
        .flag  (wrap_flag)
    );

    assign sec_count = rtc_mode ? count : '0;

    // R6: inactive block never raises the flag in the following cycle
    assert_idle_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !wrap_flag);
endmodule

// File: tb/sec_wrap_counter_bench.sv
module sec_wrap_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HZ = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        rtc_mode = 1'b1;
    logic        lim_lo_wr = 1'b0;
    logic        lim_hi_wr = 1'b0;
    logic [15:0] lim_half = '0;
    logic [31:0] sec_count;
    logic        wrap_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_wrap_counter #(.CLK_HZ(HZ)) u_sec_wrap_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .rtc_mode(rtc_mode),
        .lim_lo_wr(lim_lo_wr), .lim_hi_wr(lim_hi_wr), .lim_half(lim_half),
        .sec_count(sec_count), .wrap_flag(wrap_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_limit(input logic [31:0] v);
        lim_half = v[15:0]; lim_lo_wr = 1'b1; step(1); lim_lo_wr = 1'b0;
        lim_half = v[31:16]; lim_hi_wr = 1'b1; step(1); lim_hi_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 count after reset", sec_count, 0);
        chk("R7 flag after reset", {31'b0, wrap_flag}, 0);
    endtask

    task automatic t_period();
        en = 1'b1;
        step(HZ - 1);
        chk("R1 no tick before full period", sec_count, 0);
        step(1);
        chk("R1 first tick", sec_count, 1);
        step(HZ);
        chk("R7 all-ones limit lets count grow", sec_count, 2);
    endtask

    task automatic t_low_limit();
        en = 1'b0; step(1);
        write_limit(32'd3);
        en = 1'b1;
        step(HZ);
        chk("R3 count reaches limit", sec_count, 3);
        chk("R4 no flag at limit", {31'b0, wrap_flag}, 0);
        step(HZ);
        chk("R3 wrap past limit", sec_count, 0);
        chk("R4 flag on wrap", {31'b0, wrap_flag}, 1);
        step(1);
        chk("R4 flag is one cycle", {31'b0, wrap_flag}, 0);
        step(HZ - 1);
        chk("R3 resumes from zero", sec_count, 1);
    endtask

    task automatic t_high_half();
        en = 1'b0; step(1);
        lim_half = 16'h0001; lim_hi_wr = 1'b1; step(1); lim_hi_wr = 1'b0;
        en = 1'b1;
        step(3 * HZ);
        chk("R2 upper half widens limit", sec_count, 4);
    endtask

    task automatic t_zero_limit();
        en = 1'b0; step(1);
        write_limit(32'd0);
        en = 1'b1;
        step(HZ);
        chk("R4 limit zero wraps count", sec_count, 0);
        chk("R4 limit zero sets flag", {31'b0, wrap_flag}, 1);
        step(1);
        chk("R4 flag drops between ticks", {31'b0, wrap_flag}, 0);
        step(HZ - 1);
        chk("R4 limit zero flags again", {31'b0, wrap_flag}, 1);
    endtask

    task automatic t_disable();
        en = 1'b0; step(1);
        write_limit(32'd9);
        en = 1'b1;
        step(2 * HZ);
        chk("R6 counting before disable", sec_count, 2);
        step(2);
        en = 1'b0;
        step(5 * HZ);
        chk("R6 count held while disabled", sec_count, 2);
        chk("R6 no flag while disabled", {31'b0, wrap_flag}, 0);
        en = 1'b1;
        step(HZ - 1);
        chk("R6 divider restarts full period", sec_count, 2);
        step(1);
        chk("R6 tick after full period", sec_count, 3);
    endtask

    task automatic t_mode();
        rtc_mode = 1'b0;
        #1;
        chk("R5 read zero outside mode", sec_count, 0);
        step(2 * HZ);
        chk("R5 read zero stays outside mode", sec_count, 0);
        rtc_mode = 1'b1;
        #1;
        chk("R5 count visible again", sec_count, 3);
        step(HZ);
        chk("R6 mode off did not count", sec_count, 4);
    endtask

    task automatic t_collide();
        step(HZ - 1);
        lim_half = 16'd2; lim_lo_wr = 1'b1;
        step(1);
        lim_lo_wr = 1'b0;
        chk("R8 tick uses old limit", sec_count, 5);
        step(HZ);
        chk("R8 next tick uses new limit", sec_count, 0);
        chk("R8 wrap flag with new limit", {31'b0, wrap_flag}, 1);
    endtask

    task automatic t_midreset();
        step(HZ);
        chk("R3 count before reset", sec_count, 1);
        rst_n = 1'b0; step(1);
        chk("R7 count cleared by reset", sec_count, 0);
        rst_n = 1'b1; en = 1'b0; step(1);
        en = 1'b1;
        step(HZ);
        chk("R7 limit back to all ones", sec_count, 1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_period();
        t_low_limit();
        t_high_half();
        t_zero_limit();
        t_disable();
        t_mode();
        t_collide();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule